// File: doc/BRIEF.md
# Low-Frequency Clock Source Sequencer

This block chooses which 32.768 kHz oscillator drives the slow clock domain and runs the start and stop sequence for it. There are three candidate sources: an RC oscillator, a crystal oscillator (which can also take an external low-swing or rail-to-rail signal), and a source synthesized from the fast clock. Software writes a source configuration word and then pulses the start task. The block enables the chosen oscillator stub, waits for that stub's ready handshake, reports the running state and active source, and raises a one-cycle started event.

When the crystal is chosen, the slow clock first runs from the RC oscillator while the crystal warms up. Once the crystal reports ready, the block moves over to it on its own. The configuration is frozen from the start task until the clock is stopped. A configuration outside the legal set is never executed: the start is refused and a sticky error flag is raised. A system-off input forces the sequencer and every source off.

Top module: `lfclk_seq`

## Requirements
- R1: The configuration register keeps source code bits 1:0 (0 = RC, 1 = crystal, 2 = synthesized, 3 = reserved), the bypass flag at bit 16 and the external flag at bit 17. Every other bit reads back as 0. A write is accepted only while the sequencer is idle (start not triggered). Reset value is 0.
- R2: Only five combinations are legal: source 0 with both flags clear, source 2 with both flags clear, and source 1 with {external,bypass} equal to 00, 10 or 11. A start while idle with any other combination is ignored and sets the sticky error flag `cfg_err`.
- R3: An accepted start copies the configuration into `cfg_copy`, using the same bit layout as R1. It also raises `start_seen` on the next cycle.
- R4: A configuration write made while `start_seen` is high is dropped, and `cfg_err` is set. `cfg_err` stays set until reset.
- R5: With source 0, `rc_en` rises after the start. One cycle after `rc_ready` is sampled high, `lf_status` reads running (bit 16) with source 0.
- R6: With source 1, `rc_en` and `xo_en` both rise after the start. `xo_ext_en` and `xo_bypass_en` follow the external and bypass flags. After `rc_ready`, the status shows running on source 0 and no started event is raised. After `xo_ready`, the status shows source 1, `rc_en` falls and the started event is raised.
- R7: With source 2, `syn_en` and `hf_req` are high from the start until the stop. After `syn_ready`, the status shows running on source 2.
- R8: A stop task is ignored while the status running bit is 0.
- R9: A stop task while running turns every enable off, clears `lf_status` and clears `start_seen` on the next cycle.
- R10: While `sys_off` is high, the next cycle has no enables, no running state and `start_seen` low. A start task during `sys_off` is ignored and does not set `cfg_err`.
- R11: `started_evt` is a single-cycle pulse, raised in the first cycle that the selected source is the active one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_off | input | 1 | System off mode, forces everything off |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write word |
| cfg_rdata | output | 32 | Configuration register readback |
| cfg_copy | output | 32 | Configuration latched at the accepted start |
| start_task | input | 1 | Start task pulse |
| stop_task | input | 1 | Stop task pulse |
| rc_ready | input | 1 | RC oscillator running |
| xo_ready | input | 1 | Crystal oscillator running |
| syn_ready | input | 1 | Synthesized source running |
| rc_en | output | 1 | RC oscillator enable |
| xo_en | output | 1 | Crystal oscillator enable |
| xo_ext_en | output | 1 | Crystal path takes external signal |
| xo_bypass_en | output | 1 | Crystal amplifier bypassed for rail-to-rail input |
| syn_en | output | 1 | Synthesized source enable |
| hf_req | output | 1 | Fast clock request |
| lf_status | output | 32 | Bits 1:0 active source, bit 16 running |
| start_seen | output | 1 | Start has been triggered and not yet stopped |
| started_evt | output | 1 | Started event pulse |
| cfg_err | output | 1 | Sticky configuration error flag |

## Verification
The block has no size parameters. All register bit positions are fixed package constants, so the bench builds it with its only configuration. Because of this, all 16 combinations of source code, bypass flag and external flag can be reached, so the bench drives every legal and every prohibited combination. Random ready delays and random stop methods (task, system off, stop during the crystal warm-up bridge) reach each transition out of every state.

// File: rtl/lfclk_pkg.sv
package lfclk_pkg;
  localparam int REG_W   = 32;
  localparam int SRC_W   = 2;
  localparam int SRC_LSB = 0;
  localparam int BYP_BIT = 16;
  localparam int EXT_BIT = 17;
  localparam int RUN_BIT = 16;

  typedef enum logic [SRC_W-1:0] {
    SRC_RC  = 2'd0,
    SRC_XO  = 2'd1,
    SRC_SYN = 2'd2,
    SRC_BAD = 2'd3
  } lf_src_e;

  typedef struct packed {
    logic    ext;
    logic    byp;
    lf_src_e src;
  } lf_cfg_t;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_WAKE   = 2'd1,
    ST_BRIDGE = 2'd2,
    ST_ON     = 2'd3
  } lf_state_e;

  function automatic lf_cfg_t cfg_from_word(input logic [REG_W-1:0] w);
    lf_cfg_t c;
    c.src = lf_src_e'(w[SRC_LSB +: SRC_W]);
    c.byp = w[BYP_BIT];
    c.ext = w[EXT_BIT];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] cfg_to_word(input lf_cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[SRC_LSB +: SRC_W] = c.src;
    w[BYP_BIT] = c.byp;
    w[EXT_BIT] = c.ext;
    return w;
  endfunction

  function automatic logic cfg_legal(input lf_cfg_t c);
    case (c.src)
      SRC_RC, SRC_SYN: return !c.ext && !c.byp;
      SRC_XO:          return c.ext || !c.byp;
      default:         return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/lfclk_cfg.sv
module lfclk_cfg
  import lfclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_off,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             start_task,
  input  logic             idle,
  output lf_cfg_t          cfg_q,
  output lf_cfg_t          copy_q,
  output logic             go,
  output logic             err
);
  logic legal;
  logic start_bad;
  logic wr_locked;

  assign legal     = cfg_legal(cfg_q);
  assign go        = start_task && idle && !sys_off && legal;
  assign start_bad = start_task && idle && !sys_off && !legal;
  assign wr_locked = wr && !idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      copy_q <= '0;
      err    <= 1'b0;
    end else begin
      if (wr && idle) cfg_q <= cfg_from_word(wdata);
      if (go) copy_q <= cfg_q;
      if (start_bad || wr_locked) err <= 1'b1;
    end
  end
endmodule

// File: rtl/lfclk_fsm.sv
module lfclk_fsm
  import lfclk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sys_off,
  input  logic      go,
  input  logic      stop_task,
  input  logic      rc_ready,
  input  logic      xo_ready,
  input  logic      syn_ready,
  input  lf_src_e   sel,
  output lf_state_e st,
  output logic      running,
  output lf_src_e   act_src,
  output logic      started_evt
);
  lf_state_e nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_OFF:  if (go) nxt = ST_WAKE;
      ST_WAKE: begin
        if (sel == SRC_SYN) begin
          if (syn_ready) nxt = ST_ON;
        end else if (rc_ready) begin
          nxt = (sel == SRC_XO) ? ST_BRIDGE : ST_ON;
        end
      end
      ST_BRIDGE: begin
        if (stop_task)     nxt = ST_OFF;
        else if (xo_ready) nxt = ST_ON;
      end
      ST_ON:   if (stop_task) nxt = ST_OFF;
      default: nxt = ST_OFF;
    endcase
    if (sys_off) nxt = ST_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_OFF;
      started_evt <= 1'b0;
    end else begin
      st          <= nxt;
      started_evt <= (nxt == ST_ON) && (st != ST_ON);
    end
  end

  assign running = (st == ST_BRIDGE) || (st == ST_ON);
  assign act_src = (st == ST_ON) ? sel : SRC_RC;
endmodule

// File: rtl/lfclk_gate.sv
module lfclk_gate
  import lfclk_pkg::*;
(
  input  lf_state_e st,
  input  lf_cfg_t   sel,
  output logic      rc_en,
  output logic      xo_en,
  output logic      xo_ext_en,
  output logic      xo_bypass_en,
  output logic      syn_en,
  output logic      hf_req
);
  logic active;

  assign active = (st != ST_OFF);

  always_comb begin
    unique case (st)
      ST_WAKE:   rc_en = (sel.src != SRC_SYN);
      ST_BRIDGE: rc_en = 1'b1;
      ST_ON:     rc_en = (sel.src == SRC_RC);
      default:   rc_en = 1'b0;
    endcase
  end

  assign xo_en        = active && (sel.src == SRC_XO);
  assign xo_ext_en    = xo_en && sel.ext;
  assign xo_bypass_en = xo_en && sel.byp;
  assign syn_en       = active && (sel.src == SRC_SYN);
  assign hf_req       = active && (sel.src == SRC_SYN);
endmodule

// File: rtl/lfclk_seq.sv
module lfclk_seq
  import lfclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_off,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic [REG_W-1:0] cfg_copy,
  input  logic             start_task,
  input  logic             stop_task,
  input  logic             rc_ready,
  input  logic             xo_ready,
  input  logic             syn_ready,
  output logic             rc_en,
  output logic             xo_en,
  output logic             xo_ext_en,
  output logic             xo_bypass_en,
  output logic             syn_en,
  output logic             hf_req,
  output logic [REG_W-1:0] lf_status,
  output logic             start_seen,
  output logic             started_evt,
  output logic             cfg_err
);
  lf_cfg_t   cfg_q;
  lf_cfg_t   copy_q;
  lf_state_e st;
  lf_src_e   act_src;
  logic      go;
  logic      running;

  lfclk_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .sys_off    (sys_off),
    .wr         (cfg_wr),
    .wdata      (cfg_wdata),
    .start_task (start_task),
    .idle       (st == ST_OFF),
    .cfg_q      (cfg_q),
    .copy_q     (copy_q),
    .go         (go),
    .err        (cfg_err)
  );

  lfclk_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_off     (sys_off),
    .go          (go),
    .stop_task   (stop_task),
    .rc_ready    (rc_ready),
    .xo_ready    (xo_ready),
    .syn_ready   (syn_ready),
    .sel         (copy_q.src),
    .st          (st),
    .running     (running),
    .act_src     (act_src),
    .started_evt (started_evt)
  );

  lfclk_gate u_gate (
    .st           (st),
    .sel          (copy_q),
    .rc_en        (rc_en),
    .xo_en        (xo_en),
    .xo_ext_en    (xo_ext_en),
    .xo_bypass_en (xo_bypass_en),
    .syn_en       (syn_en),
    .hf_req       (hf_req)
  );

  always_comb begin
    lf_status = '0;
    lf_status[SRC_LSB +: SRC_W] = act_src;
    lf_status[RUN_BIT] = running;
  end

  assign cfg_rdata  = cfg_to_word(cfg_q);
  assign cfg_copy   = cfg_to_word(copy_q);
  assign start_seen = (st != ST_OFF);
endmodule

// File: rtl/lfclk_seq_chk.sv
module lfclk_seq_chk
  import lfclk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sys_off,
  input logic             stop_task,
  input logic [REG_W-1:0] cfg_rdata,
  input logic [REG_W-1:0] cfg_copy,
  input logic             rc_en,
  input logic             xo_en,
  input logic             syn_en,
  input logic             hf_req,
  input logic [REG_W-1:0] lf_status,
  input logic             start_seen,
  input logic             started_evt
);
  p_cfg_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lf_status[RUN_BIT] |=> $stable(cfg_rdata));

  p_force_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_off |=> !(rc_en || xo_en || syn_en || lf_status[RUN_BIT] || start_seen));

  p_fast_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lf_status[RUN_BIT] && lf_status[SRC_LSB +: SRC_W] == SRC_SYN) |-> hf_req);

  p_evt_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    started_evt |=> !started_evt);

  p_xo_switch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (started_evt && cfg_copy[SRC_LSB +: SRC_W] == SRC_XO)
      |-> (lf_status[SRC_LSB +: SRC_W] == SRC_XO && !rc_en));

  p_stop_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_seen && !lf_status[RUN_BIT] && stop_task && !sys_off) |=> start_seen);

  p_one_remote_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xo_en, syn_en}));
endmodule

bind lfclk_seq lfclk_seq_chk u_chk (.*);

// File: tb/test_lfclk_seq.sv
module test_lfclk_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sys_off = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata, cfg_copy, lf_status;
  logic        start_task = 1'b0, stop_task = 1'b0;
  logic        rc_ready = 1'b0, xo_ready = 1'b0, syn_ready = 1'b0;
  logic        rc_en, xo_en, xo_ext_en, xo_bypass_en, syn_en, hf_req;
  logic        start_seen, started_evt, cfg_err;

  int checks = 0;
  int fails = 0;
  logic err_exp = 1'b0;
  logic [31:0] reg_exp = '0;

  always #10 clk = ~clk;

  lfclk_seq i_lfclk_seq (.*);

  function automatic logic [31:0] mask_w(input logic [31:0] w);
    return w & 32'h0003_0003;
  endfunction

  function automatic logic legal_w(input logic [31:0] w);
    case (w[1:0])
      2'd0, 2'd2: return (w[17:16] == 2'b00);
      2'd1:       return (w[17:16] != 2'b01);
      default:    return 1'b0;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    tick();
    err_exp = 1'b0;
    reg_exp = '0;
  endtask

  task automatic wr(input logic [31:0] w);
    cfg_wr = 1'b1;
    cfg_wdata = w;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_start();
    start_task = 1'b1;
    tick();
    start_task = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_task = 1'b1;
    tick();
    stop_task = 1'b0;
  endtask

  task automatic chk_all_off(input string tag);
    chk({rc_en, xo_en, syn_en, hf_req, start_seen}, '0, tag);
    chk(lf_status, 32'h0, tag);
  endtask

  task automatic run_one(input logic [31:0] w, input int stop_mode);
    logic [1:0] src;
    src = w[1:0];
    wr(w);
    reg_exp = mask_w(w);
    chk(cfg_rdata, reg_exp, "R1 readback");
    pulse_start();
    if (!legal_w(w)) begin
      err_exp = 1'b1;
      chk({31'd0, start_seen}, 32'd0, "R2 illegal start ignored");
      chk({31'd0, cfg_err}, {31'd0, err_exp}, "R2 error flag");
      return;
    end
    chk({31'd0, start_seen}, 32'd1, "R3 start_seen");
    chk(cfg_copy, reg_exp, "R3 copy");
    chk(lf_status, 32'h0, "R8 not running yet");
    pulse_stop();
    chk({31'd0, start_seen}, 32'd1, "R8 early stop ignored");
    wr(32'h0000_0002);
    err_exp = 1'b1;
    chk(cfg_rdata, reg_exp, "R4 locked write dropped");
    chk({31'd0, cfg_err}, 32'd1, "R4 sticky error");
    case (src)
      2'd0: begin
        chk({29'd0, rc_en, xo_en, syn_en}, 32'b100, "R5 rc enable");
        rc_ready = 1'b1;
        tick();
        chk(lf_status, 32'h0001_0000, "R5 running on rc");
        chk({31'd0, started_evt}, 32'd1, "R11 event");
      end
      2'd1: begin
        chk({27'd0, rc_en, xo_en, syn_en, xo_ext_en, xo_bypass_en},
            {27'd0, 3'b110, w[17], w[16]}, "R6 enables");
        rc_ready = 1'b1;
        tick();
        chk(lf_status, 32'h0001_0000, "R6 bridge on rc");
        chk({31'd0, started_evt}, 32'd0, "R6 no event in bridge");
        if (stop_mode == 2) begin
          pulse_stop();
          chk_all_off("R9 stop in bridge");
          rc_ready = 1'b0;
          return;
        end
        for (int k = 0; k < int'($urandom_range(0, 4)); k++) tick();
        chk({31'd0, rc_en}, 32'd1, "R6 rc held in bridge");
        xo_ready = 1'b1;
        tick();
        chk(lf_status, 32'h0001_0001, "R6 switched to crystal");
        chk({31'd0, rc_en}, 32'd0, "R6 rc released");
        chk({31'd0, started_evt}, 32'd1, "R11 event");
      end
      default: begin
        chk({27'd0, rc_en, xo_en, syn_en, hf_req}, 32'b0011, "R7 synth enables");
        syn_ready = 1'b1;
        tick();
        chk(lf_status, 32'h0001_0002, "R7 running on synth");
        chk({31'd0, hf_req}, 32'd1, "R7 fast clock request");
        chk({31'd0, started_evt}, 32'd1, "R11 event");
      end
    endcase
    tick();
    chk({31'd0, started_evt}, 32'd0, "R11 single pulse");
    if (stop_mode == 1) begin
      sys_off = 1'b1;
      tick();
      sys_off = 1'b0;
      chk_all_off("R10 system off");
    end else begin
      pulse_stop();
      chk_all_off("R9 stop");
    end
    rc_ready = 1'b0;
    xo_ready = 1'b0;
    syn_ready = 1'b0;
    chk({31'd0, cfg_err}, {31'd0, err_exp}, "R4 error persists");
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd1234));
    do_reset();
    chk(cfg_rdata, 32'h0, "R1 reset value");
    chk_all_off("R9 reset state");
    chk({31'd0, cfg_err}, 32'd0, "R2 reset error");

    wr(32'hFFFF_FFFF);
    chk(cfg_rdata, 32'h0003_0003, "R1 unused bits zero");

    do_reset();
    wr(32'h0000_0001);
    sys_off = 1'b1;
    start_task = 1'b1;
    tick();
    start_task = 1'b0;
    tick();
    chk({31'd0, start_seen}, 32'd0, "R10 start ignored in off");
    chk({31'd0, cfg_err}, 32'd0, "R10 no error");
    sys_off = 1'b0;
    tick();

    for (int c = 0; c < 16; c++) begin
      do_reset();
      w = {14'd0, c[3:2], 14'd0, c[1:0]};
      run_one(w, c % 3);
    end

    for (int i = 0; i < 60; i++) begin
      int pick;
      if (($urandom % 4) == 0) do_reset();
      pick = int'($urandom_range(0, 5));
      w = $urandom & 32'hFFFC_FFFC;
      case (pick)
        0: w = w | 32'h0000_0000;
        1: w = w | 32'h0000_0002;
        2: w = w | 32'h0000_0001;
        3: w = w | 32'h0002_0001;
        4: w = w | 32'h0003_0001;
        default: w = $urandom;
      endcase
      run_one(w, int'($urandom_range(0, 2)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule